// File: doc/BRIEF.md
# Low-Power Wake-Up Clock Sequencer

This controller decides when a microcontroller core may resume after a low-power mode, and from which clock. Software picks a system oscillator (fast crystal, fast RC, slow RC or slow crystal), a low-power mode, and whether fast wake-up is allowed. It then pulses a sleep request. The controller captures those three settings at that moment and drops the core run enable. A later wake event is passed through a two-stage synchroniser and starts a stabilisation count. The count uses the tick strobes of the captured oscillator. Every oscillator's ticks arrive as single-cycle enable strobes in the one reference clock domain, so the whole design is synchronous.

When the fast crystal is selected, fast wake-up is enabled, and the mode exited keeps the sub-clock alive, the core restarts early on the sub-clock. The crystal count carries on in the background. When that count completes, the high-speed-ready flag rises and the clock select hands back to the crystal on the same edge. All pins are plain control and status levels or pulses. There is no data stream, so no valid/ready handshake applies.

Mode codes on `lp_mode`: 0 deep sleep (every oscillator stopped), 1 sleep with the sub-clock kept, 2 idle with the sub-clock kept, 3 idle with the system oscillator kept. Oscillator codes on `osc_sel`: 0 fast crystal, 1 fast RC, 2 slow RC, 3 slow crystal.

Top module: `wake_clk_seq`

## Requirements
- R1: After reset, `cpu_run` is 1, `hs_ready` is 1 and `clk_on_sub` is 0.
- R2: A `sleep_req` sampled while `cpu_run` is 1 and `clk_on_sub` is 0 makes `cpu_run` 0 after that edge. It also captures `osc_sel`, `lp_mode` and `fast_wake_en`, so later changes on those pins have no effect until the next sleep. A `sleep_req` at any other time is ignored.
- R3: Entering mode 0, 1 or 2 clears `hs_ready` on the accepting edge. Entering mode 3 leaves it at 1. It returns to 1 on the edge where a wake-up completes.
- R4: `wake_evt` passes two synchroniser flops, so no strobe is counted before the third edge after the wake pulse. A wake event while `cpu_run` is 1, or while a count is already running, is ignored. Strobes seen before the wake are not counted.
- R5: Leaving mode 3 with any oscillator, `cpu_run` rises on the edge of the 2nd strobe of the captured oscillator.
- R6: With the slow RC (code 2), `cpu_run` rises on its 2nd strobe in every mode, whatever the fast-wake bit is.
- R7: With the fast RC (code 1), leaving mode 0, 1 or 2, `cpu_run` rises on its 16th strobe, whatever the fast-wake bit is.
- R8: With the slow crystal (code 3), leaving mode 0, 1 or 2, `cpu_run` rises on its 128th strobe.
- R9: With the fast crystal (code 0), leaving mode 0, or leaving any mode but 3 with fast wake-up off, `cpu_run` rises on its 128th strobe. The fast-wake bit and `tick_sub` have no effect when leaving mode 0.
- R10: With the fast crystal, fast wake-up on, and mode 1 or 2 exited, the 2nd `tick_sub` strobe raises `cpu_run` and `clk_on_sub` while `hs_ready` stays 0. Later, the edge of the 128th fast-crystal strobe counted since the wake raises `hs_ready` and clears `clk_on_sub`, and `cpu_run` stays 1 throughout.
- R11: Strobes from oscillators other than the one being counted do not advance any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_sel | input | 2 | System oscillator code, captured at sleep |
| lp_mode | input | 2 | Low-power mode code, captured at sleep |
| fast_wake_en | input | 1 | Fast wake-up enable, captured at sleep |
| sleep_req | input | 1 | One-cycle request to enter the selected mode |
| wake_evt | input | 1 | Asynchronous wake event |
| tick_xhi | input | 1 | Fast crystal tick strobe |
| tick_rhi | input | 1 | Fast RC tick strobe |
| tick_rlo | input | 1 | Slow RC tick strobe |
| tick_xlo | input | 1 | Slow crystal tick strobe |
| tick_sub | input | 1 | Sub-clock tick strobe |
| cpu_run | output | 1 | Core run enable |
| clk_on_sub | output | 1 | 1 while the core is clocked from the sub-clock |
| hs_ready | output | 1 | High-speed oscillator stable flag |

## Verification
A wrong captured setting or a wrong target count shows directly on `cpu_run`. It rises one strobe early, or it fails to rise on the edge of the expected final strobe, so the error is visible within the same wake-up. A counter that follows the wrong oscillator shows the same way, because stray strobes from other oscillators are mixed into every wait. A broken hand-over shows within one cycle of the 128th crystal strobe: `clk_on_sub` stays high, or `hs_ready` rises with it still set. A wrong flag update on sleep entry shows on `hs_ready` on the edge after the request.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    OSC_XTAL_HI = 2'd0,
    OSC_RC_HI   = 2'd1,
    OSC_RC_LO   = 2'd2,
    OSC_XTAL_LO = 2'd3
  } osc_e;

  typedef enum logic [1:0] {
    LP_DEEP     = 2'd0,
    LP_SUBKEEP  = 2'd1,
    LP_IDLE_SUB = 2'd2,
    LP_IDLE_SYS = 2'd3
  } lp_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FAST = 2'd3
  } seq_st_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_plan.sv
module wake_plan
  import wake_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SHORT_TICKS = 2,
  parameter int MID_TICKS   = 16,
  parameter int LONG_TICKS  = 128
) (
  input  logic [1:0]    osc,
  input  logic [1:0]    mode,
  input  logic          fast,
  output logic [CW-1:0] target,
  output logic          use_fast
);
  logic keeps_sub;

  assign keeps_sub = (mode == LP_SUBKEEP) || (mode == LP_IDLE_SUB);
  assign use_fast  = (osc == OSC_XTAL_HI) && fast && keeps_sub;

  always_comb begin
    if (mode == LP_IDLE_SYS || osc == OSC_RC_LO) target = CW'(SHORT_TICKS);
    else if (osc == OSC_RC_HI)                   target = CW'(MID_TICKS);
    else                                         target = CW'(LONG_TICKS);
  end
endmodule

// File: rtl/wake_tick_cnt.sv
module wake_tick_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign done = tick && (nxt >= {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= nxt[CW-1:0];
  end
endmodule

// File: rtl/wake_clk_seq.sv
module wake_clk_seq
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_TICKS = 2,
  parameter int MID_TICKS   = 16,
  parameter int LONG_TICKS  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] osc_sel,
  input  logic [1:0] lp_mode,
  input  logic       fast_wake_en,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       tick_xhi,
  input  logic       tick_rhi,
  input  logic       tick_rlo,
  input  logic       tick_xlo,
  input  logic       tick_sub,
  output logic       cpu_run,
  output logic       clk_on_sub,
  output logic       hs_ready
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  seq_st_e       st;
  logic [1:0]    lat_osc;
  logic [1:0]    lat_mode;
  logic          lat_fast;
  logic          wake_s;
  logic [CW-1:0] main_target;
  logic          use_fast;
  logic [3:0]    sys_ticks;
  logic          counting;
  logic          main_tick, sub_tick_g;
  logic          main_done, sub_done;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_evt), .q(wake_s)
  );

  wake_plan #(
    .CW(CW), .SHORT_TICKS(SHORT_TICKS),
    .MID_TICKS(MID_TICKS), .LONG_TICKS(LONG_TICKS)
  ) u_plan (
    .osc(lat_osc), .mode(lat_mode), .fast(lat_fast),
    .target(main_target), .use_fast(use_fast)
  );

  assign sys_ticks  = {tick_xlo, tick_rlo, tick_rhi, tick_xhi};
  assign counting   = (st == ST_WAIT) || (st == ST_FAST);
  assign main_tick  = counting && sys_ticks[lat_osc];
  assign sub_tick_g = (st == ST_WAIT) && use_fast && tick_sub;

  wake_tick_cnt #(.CW(CW)) u_main_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_LOW),
    .tick(main_tick), .target(main_target), .done(main_done)
  );

  wake_tick_cnt #(.CW(CW)) u_sub_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_LOW),
    .tick(sub_tick_g), .target(CW'(SHORT_TICKS)), .done(sub_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      lat_osc    <= '0;
      lat_mode   <= '0;
      lat_fast   <= 1'b0;
      clk_on_sub <= 1'b0;
      hs_ready   <= 1'b1;
    end else begin
      unique case (st)
        ST_RUN: if (sleep_req) begin
          st       <= ST_LOW;
          lat_osc  <= osc_sel;
          lat_mode <= lp_mode;
          lat_fast <= fast_wake_en;
          if (lp_mode != LP_IDLE_SYS) hs_ready <= 1'b0;
        end
        ST_LOW: if (wake_s) st <= ST_WAIT;
        ST_WAIT: begin
          if (main_done) begin
            st       <= ST_RUN;
            hs_ready <= 1'b1;
          end else if (sub_done) begin
            st         <= ST_FAST;
            clk_on_sub <= 1'b1;
          end
        end
        ST_FAST: if (main_done) begin
          st         <= ST_RUN;
          clk_on_sub <= 1'b0;
          hs_ready   <= 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign cpu_run = (st == ST_RUN) || (st == ST_FAST);
endmodule

// File: rtl/wake_clk_seq_chk.sv
module wake_clk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lp_mode,
  input logic       sleep_req,
  input logic       cpu_run,
  input logic       clk_on_sub,
  input logic       hs_ready
);
  a_r2_sleep_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && cpu_run && !clk_on_sub) |=> !cpu_run);

  a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && cpu_run && !clk_on_sub && lp_mode != 2'd3) |=> !hs_ready);

  a_r3_flag_kept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && cpu_run && !clk_on_sub && lp_mode == 2'd3) |=> hs_ready);

  a_r4_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !clk_on_sub && !sleep_req) |=> cpu_run);

  a_r10_sub_running: assert property (@(posedge clk) disable iff (!rst_n)
    clk_on_sub |-> (cpu_run && !hs_ready));

  a_r10_sub_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    clk_on_sub |=> cpu_run);

  a_r10_handover: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_on_sub) |-> (hs_ready && cpu_run));
endmodule

bind wake_clk_seq wake_clk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .sleep_req(sleep_req),
  .cpu_run(cpu_run), .clk_on_sub(clk_on_sub), .hs_ready(hs_ready)
);

// File: tb/wake_clk_seq_tb.sv
module wake_clk_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] osc_sel = '0;
  logic [1:0] lp_mode = '0;
  logic       fast_wake_en = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic [4:0] tk = '0;
  logic       cpu_run, clk_on_sub, hs_ready;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  wake_clk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .osc_sel(osc_sel), .lp_mode(lp_mode),
    .fast_wake_en(fast_wake_en), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .tick_xhi(tk[0]), .tick_rhi(tk[1]), .tick_rlo(tk[2]), .tick_xlo(tk[3]),
    .tick_sub(tk[4]), .cpu_run(cpu_run), .clk_on_sub(clk_on_sub),
    .hs_ready(hs_ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] v, input logic wk, input logic sr);
    tk = v; wake_evt = wk; sleep_req = sr;
    @(posedge clk); #2;
    tk = '0; wake_evt = 1'b0; sleep_req = 1'b0;
  endtask

  function automatic int exp_len(input int osc, input int mode);
    if (mode == 3 || osc == 2) return 2;
    if (osc == 1) return 16;
    return 128;
  endfunction

  function automatic bit fast_applies(input int osc, input int mode, input bit f);
    return (osc == 0) && f && (mode == 1 || mode == 2);
  endfunction

  function automatic string rtag(input int osc, input int mode, input bit f);
    if (mode == 3) return "R5";
    if (osc == 2) return "R6";
    if (osc == 1) return "R7";
    if (osc == 3) return "R8";
    if (fast_applies(osc, mode, f)) return "R10";
    return "R9";
  endfunction

  task automatic gaps(input logic [4:0] mask, input bit extra);
    int g = $urandom_range(0, 2);
    for (int k = 0; k < g; k++)
      cyc(5'($urandom) & ~mask, extra && ($urandom_range(0, 15) == 0),
          extra && ($urandom_range(0, 15) == 0));
  endtask

  task automatic count_ticks(input int n, input logic [4:0] bitv, input logic [4:0] mask,
                             input string req, input bit is_ready_phase);
    for (int i = 1; i <= n; i++) begin
      gaps(mask, 1'b1);
      if (i == n) begin
        if (is_ready_phase) chk("R11", "hs_ready before last strobe", int'(hs_ready), 0);
        else                chk("R11", "cpu_run before last strobe", int'(cpu_run), 0);
      end
      cyc(bitv, 1'b0, 1'b0);
    end
    if (is_ready_phase) begin
      chk(req, "hs_ready after count", int'(hs_ready), 1);
      chk(req, "clk_on_sub after handover", int'(clk_on_sub), 0);
      chk(req, "cpu_run through handover", int'(cpu_run), 1);
    end else begin
      chk(req, "cpu_run after count", int'(cpu_run), 1);
    end
  endtask

  task automatic trial(input int osc, input int mode, input bit f);
    string req = rtag(osc, mode, f);
    bit    fa  = fast_applies(osc, mode, f);
    logic [4:0] mask;
    osc_sel = 2'(osc); lp_mode = 2'(mode); fast_wake_en = f;
    cyc(5'b0, 1'b0, 1'b1);
    chk("R2", "cpu_run after sleep", int'(cpu_run), 0);
    chk("R3", "hs_ready on entry", int'(hs_ready), (mode == 3) ? 1 : 0);
    // R2: settings were captured; scramble the pins now
    osc_sel = 2'($urandom); lp_mode = 2'($urandom); fast_wake_en = 1'($urandom);
    for (int k = 0; k < 3; k++) cyc(5'($urandom), 1'b0, 1'b0);
    chk("R4", "asleep before wake", int'(cpu_run), 0);
    cyc(5'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) cyc(5'b0, 1'b0, 1'b0);
    if (fa) begin
      mask = 5'b10001;
      count_ticks(2, 5'b10000, mask, "R10", 1'b0);
      chk("R10", "clk_on_sub after sub count", int'(clk_on_sub), 1);
      chk("R10", "hs_ready on sub clock", int'(hs_ready), 0);
      cyc(5'b0, 1'b0, 1'b1);
      chk("R2", "sleep ignored on sub clock", int'(cpu_run), 1);
      count_ticks(128, 5'b00001, mask, "R10", 1'b1);
    end else begin
      mask = 5'(1 << osc);
      count_ticks(exp_len(osc, mode), mask, mask, req, 1'b0);
      chk("R3", "hs_ready after wake", int'(hs_ready), 1);
      chk(req, "clk_on_sub stays low", int'(clk_on_sub), 0);
    end
    cyc(5'b0, 1'b0, 1'b0);
    cyc(5'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd9137));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1", "cpu_run reset", int'(cpu_run), 1);
    chk("R1", "hs_ready reset", int'(hs_ready), 1);
    chk("R1", "clk_on_sub reset", int'(clk_on_sub), 0);
    for (int k = 0; k < 4; k++) cyc(5'($urandom), 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) cyc(5'b0, 1'b0, 1'b0);
    chk("R4", "wake while running ignored", int'(cpu_run), 1);
    trial(0, 0, 1'b1);
    trial(0, 1, 1'b1);
    trial(0, 2, 1'b1);
    trial(0, 1, 1'b0);
    trial(1, 0, 1'b1);
    trial(2, 3, 1'b0);
    trial(2, 0, 1'b1);
    trial(3, 1, 1'b0);
    trial(3, 3, 1'b1);
    trial(0, 3, 1'b1);
    for (int t = 0; t < 20; t++)
      trial($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule